// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the device-side agent on a single-wire, open-drain serial interrupt bus. It holds a vector of local request levels, one per numbered frame, and reports the level of every frame it owns to the host. The host sees these levels in a fixed slot after the start pulse. The bus wire is modelled as three signals: the resolved line level as an input, plus an output enable and an output value. Pull-up and tri-state resolution sit outside the block.

Each bus cycle opens with a start pulse and is followed by data frames of three clocks each, then a stop pulse. The agent finds the clock in which the line first reads high after the start pulse and counts frames from that point. In each owned slot it drives the line low, then high, then releases it. It also measures the width of every stop pulse, which tells it whether the next idle period is continuous or quiet. In quiet mode, an owned level that differs from the level last reported makes the agent start a cycle by pulling the line low for one clock.

Top module: `irq_serial_agent`

## Requirements
- R1: While reset is held and after it is released, the agent leaves the line released (enable 0) and is in continuous mode.
- R2: In quiet mode, when the line is read high while the agent is idle and an owned request level differs from the level last reported, the agent drives the line low (enable 1, value 0) for exactly one clock. The kick appears two clocks after the request input changes. It releases the line on the next clock and never drives it high as part of that pulse.
- R3: The agent never starts a cycle in continuous mode. In either mode it never starts one while a cycle is running, from start pulse to stop pulse.
- R4: Frame k (0-based, k = 0 .. NFRAMES-1) has its sample clock 3k+2 clocks after the edge clock, the first clock in which the line reads high after the start pulse. The edge clock counts as clock 0. The agent releases the line in clocks 0 and 1.
- R5: In the sample clock of frame k, the agent drives low only if own_i[k] is 1 and the captured level of req_i[k] is 0. Otherwise it leaves the line released.
- R6: In the clock after a sample clock (recovery), the agent drives high (enable 1, value 1) only if it drove low in that sample clock. In the third clock of the frame (turn-around), it always releases the line.
- R7: The level reported in a slot is req_i as registered at the clock edge that opens the sample clock, with the default of one capture stage. A change that first reaches the register at a later edge is not reported in that slot.
- R8: A change on an owned input that is captured by its slot's sample clock is delivered in the running cycle, and no further cycle is started for it. A change captured later leaves that slot pending. In quiet mode it causes a start pulse on the second clock after the stop pulse ends.
- R9: A stop pulse of at most 2 low clocks selects quiet mode. A stop pulse of 3 or more low clocks selects continuous mode. The mode changes only at the end of a stop pulse.
- R10: Owned slots are reported the same way whether the host or the agent started the cycle.
- R11: From the end of the last frame's turn-around until the agent is idle again, the agent leaves the line released during the stop pulse. NFRAMES defaults to 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Resolved level of the bus line |
| line_oe_o | output | 1 | 1 when the agent drives the line |
| line_o | output | 1 | Level driven when line_oe_o is 1 |
| req_i | input | NFRAMES | Request level per frame, 0 = asserted |
| own_i | input | NFRAMES | 1 marks a frame that this agent reports |

## Verification
Two functions can fall in the same clock: an owned request changes in the clock that is its own slot's sample clock, and the bus is reporting that slot. The bench makes the change one clock before the sample clock of one slot, and exactly in the sample clock of another. In the first case it expects the low level in that same slot and no further start pulse. In the second case it expects the slot released, and then a start pulse from the agent on the second clock after the stop pulse. That start pulse opens a cycle that carries the late level.

// File: rtl/irq_serial_pkg.sv
package irq_serial_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_KICK  = 3'd1,
      ST_START = 3'd2,
      ST_LEAD  = 3'd3,
      ST_DATA  = 3'd4,
      ST_STOP  = 3'd5
   } bus_state_e;

   typedef enum logic [1:0] {
      PH_SAMPLE  = 2'd0,
      PH_RECOVER = 2'd1,
      PH_TURN    = 2'd2
   } frame_phase_e;

   function automatic int frm_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int cnt_width(input int n);
      return (n <= 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_serial_timer.sv
module irq_serial_timer
   import irq_serial_pkg::*;
#(
   parameter int NFRAMES = 21,
   parameter int FRM_W   = frm_width(NFRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_i,
   input  logic               quiet_i,
   input  logic               want_kick_i,
   input  logic               stop_done_i,
   output bus_state_e         st_o,
   output logic [FRM_W-1:0]   frm_o,
   output frame_phase_e       ph_o
);

   localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(NFRAMES - 1);

   bus_state_e       st_q, st_d;
   logic [FRM_W-1:0] frm_q, frm_d;
   frame_phase_e     ph_q, ph_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         frm_q <= '0;
         ph_q  <= PH_SAMPLE;
      end else begin
         st_q  <= st_d;
         frm_q <= frm_d;
         ph_q  <= ph_d;
      end
   end

   always_comb begin
      st_d  = st_q;
      frm_d = frm_q;
      ph_d  = ph_q;
      unique case (st_q)
         ST_IDLE: begin
            if (!line_i)
               st_d = ST_START;
            else if (quiet_i && want_kick_i)
               st_d = ST_KICK;
         end
         ST_KICK:  st_d = ST_START;
         ST_START: begin
            if (line_i)
               st_d = ST_LEAD;
         end
         ST_LEAD: begin
            st_d  = ST_DATA;
            frm_d = '0;
            ph_d  = PH_SAMPLE;
         end
         ST_DATA: begin
            unique case (ph_q)
               PH_SAMPLE:  ph_d = PH_RECOVER;
               PH_RECOVER: ph_d = PH_TURN;
               default: begin
                  ph_d = PH_SAMPLE;
                  if (frm_q == LAST_FRM)
                     st_d = ST_STOP;
                  else
                     frm_d = frm_q + FRM_W'(1);
               end
            endcase
         end
         ST_STOP: begin
            if (stop_done_i)
               st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign st_o  = st_q;
   assign frm_o = frm_q;
   assign ph_o  = ph_q;

   // R4: the first sample clock comes straight after the single lead clock
   a_r4_first_sample_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && ph_q == PH_SAMPLE && frm_q == '0) |-> $past(st_q) == ST_LEAD);

   // R3: a start pulse is issued only from idle with the line high
   a_r3_kick_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_KICK) |-> ($past(st_q) == ST_IDLE && $past(line_i)));

endmodule

// File: rtl/irq_serial_stop_meter.sv
module irq_serial_stop_meter
   import irq_serial_pkg::*;
#(
   parameter int QUIET_MAX = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_stop_i,
   input  logic line_i,
   output logic done_o,
   output logic quiet_o
);

   localparam int CNT_MAX = QUIET_MAX + 1;
   localparam int CNT_W   = cnt_width(CNT_MAX);

   generate
      if (QUIET_MAX < 1)
         $error("QUIET_MAX must be at least 1");
   endgenerate

   logic [CNT_W-1:0] low_cnt_q;
   logic             quiet_q;

   assign done_o = in_stop_i && line_i && (low_cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         quiet_q   <= 1'b0;
      end else if (!in_stop_i || done_o) begin
         low_cnt_q <= '0;
         if (done_o)
            quiet_q <= (low_cnt_q <= CNT_W'(QUIET_MAX));
      end else if (!line_i && low_cnt_q != CNT_W'(CNT_MAX)) begin
         low_cnt_q <= low_cnt_q + CNT_W'(1);
      end
   end

   assign quiet_o = quiet_q;

   // R9: the mode register only moves as a stop pulse closes
   a_r9_mode_only_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quiet_q) |-> $past(in_stop_i && line_i));

endmodule

// File: rtl/irq_serial_slot_driver.sv
module irq_serial_slot_driver
   import irq_serial_pkg::*;
#(
   parameter int NFRAMES    = 21,
   parameter int FRM_W      = frm_width(NFRAMES),
   parameter int REQ_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NFRAMES-1:0] req_i,
   input  logic [NFRAMES-1:0] own_i,
   input  bus_state_e         st_i,
   input  logic [FRM_W-1:0]   frm_i,
   input  frame_phase_e       ph_i,
   output logic               drv_oe_o,
   output logic               drv_o,
   output logic               pend_o
);

   generate
      if (REQ_STAGES < 1 || REQ_STAGES > 3)
         $error("REQ_STAGES must be 1, 2 or 3");
   endgenerate

   logic [NFRAMES-1:0] lat;

   generate
      if (REQ_STAGES == 1) begin : g_single
         logic [NFRAMES-1:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= '1;
            else        cap_q <= req_i;
         end
         assign lat = cap_q;
      end else begin : g_chain
         logic [NFRAMES-1:0] pipe_q [REQ_STAGES];
         for (genvar s = 0; s < REQ_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      pipe_q[s] <= '1;
               else if (s == 0) pipe_q[s] <= req_i;
               else             pipe_q[s] <= pipe_q[(s > 0) ? s - 1 : 0];
            end
         end
         assign lat = pipe_q[REQ_STAGES-1];
      end
   endgenerate

   logic [NFRAMES-1:0] sent_q;
   logic               drove_q;
   logic               is_sample, is_recover, slot_low;

   assign is_sample  = (st_i == ST_DATA) && (ph_i == PH_SAMPLE);
   assign is_recover = (st_i == ST_DATA) && (ph_i == PH_RECOVER);
   assign slot_low   = own_i[frm_i] && !lat[frm_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q  <= '1;
         drove_q <= 1'b0;
      end else begin
         drove_q <= is_sample && slot_low;
         if (is_sample && own_i[frm_i])
            sent_q[frm_i] <= lat[frm_i];
      end
   end

   assign drv_oe_o = (is_sample && slot_low) || (is_recover && drove_q);
   assign drv_o    = is_recover;
   assign pend_o   = |(own_i & (lat ^ sent_q));

endmodule

// File: rtl/irq_serial_agent.sv
module irq_serial_agent
   import irq_serial_pkg::*;
#(
   parameter int NFRAMES    = 21,
   parameter int QUIET_MAX  = 2,
   parameter int REQ_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_i,
   output logic               line_oe_o,
   output logic               line_o,
   input  logic [NFRAMES-1:0] req_i,
   input  logic [NFRAMES-1:0] own_i
);

   localparam int FRM_W = frm_width(NFRAMES);

   generate
      if (NFRAMES < 1 || NFRAMES > 64)
         $error("NFRAMES must lie in 1..64");
   endgenerate

   bus_state_e       st;
   logic [FRM_W-1:0] frm;
   frame_phase_e     ph;
   logic             quiet, stop_done, pend, drv_oe, drv_val, kicking;

   irq_serial_timer #(.NFRAMES(NFRAMES), .FRM_W(FRM_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i),
      .quiet_i     (quiet),
      .want_kick_i (pend),
      .stop_done_i (stop_done),
      .st_o        (st),
      .frm_o       (frm),
      .ph_o        (ph)
   );

   irq_serial_stop_meter #(.QUIET_MAX(QUIET_MAX)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_stop_i (st == ST_STOP),
      .line_i    (line_i),
      .done_o    (stop_done),
      .quiet_o   (quiet)
   );

   irq_serial_slot_driver #(.NFRAMES(NFRAMES), .FRM_W(FRM_W), .REQ_STAGES(REQ_STAGES)) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .own_i    (own_i),
      .st_i     (st),
      .frm_i    (frm),
      .ph_i     (ph),
      .drv_oe_o (drv_oe),
      .drv_o    (drv_val),
      .pend_o   (pend)
   );

   assign kicking   = (st == ST_KICK);
   assign line_oe_o = kicking || drv_oe;
   assign line_o    = !kicking && drv_val;

   // R2: the start pulse is one low clock, then the line is let go
   a_r2_kick_low_once: assert property (@(posedge clk) disable iff (!rst_n)
      kicking |-> (line_oe_o && !line_o) ##1 !line_oe_o);

   // R3: no start pulse outside quiet mode
   a_r3_kick_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      kicking |-> quiet);

   // R6: a high drive always follows a low drive in the clock before
   a_r6_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe_o && line_o) |-> $past(line_oe_o && !line_o));

   // R6: turn-around clock is always released
   a_r6_turn_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && ph == PH_TURN) |-> !line_oe_o);

   // R11: the stop pulse belongs to the host
   a_r11_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> !line_oe_o);

endmodule

// File: tb/tb_irq_serial_agent.sv
module tb_irq_serial_agent;

   localparam int NF   = 21;
   localparam int SPAN = 3 * NF + 2;

   typedef struct packed {
      logic [7:0]    start_low;
      logic [3:0]    stop_low;
      logic [NF-1:0] own;
      logic [NF-1:0] req;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{8'd4, 4'd3, 21'h1FFFFF, 21'h1FFFFF},
      '{8'd5, 4'd3, 21'h1FFFFF, 21'h0AAAAA},
      '{8'd6, 4'd3, 21'h00F0F0, 21'h000000},
      '{8'd7, 4'd3, 21'h1FFFFF, 21'h000000},
      '{8'd8, 4'd3, 21'h100001, 21'h000000},
      '{8'd4, 4'd4, 21'h155555, 21'h0F0F0F}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic [NF-1:0] req = '1;
   logic [NF-1:0] own = '1;
   logic line, line_oe, line_o;
   logic s_oe, s_o;
   int checks = 0, fails = 0, cyc = 0;

   always #4 clk = ~clk;

   assign line = !((line_oe && !line_o) || host_low);

   irq_serial_agent #(.NFRAMES(NF)) dut (
      .clk(clk), .rst_n(rst_n), .line_i(line),
      .line_oe_o(line_oe), .line_o(line_o),
      .req_i(req), .own_i(own)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic step(input logic h);
      @(negedge clk);
      s_oe = line_oe;
      s_o = line_o;
      host_low = h;
   endtask

   task automatic quiet_watch(input int n, input string rq);
      bit dr = 0;
      repeat (n) begin step(1'b0); dr |= s_oe; end
      chk(!dr, rq, "line stays released while idle", int'(dr), 0);
   endtask

   task automatic do_cycle(input bit host_start, input int start_low, input int stop_low,
                           input logic [NF-1:0] expv, input int chg_j, input int chg_bit,
                           input logic chg_val, input string tag);
      logic oe_l [SPAN];
      logic o_l  [SPAN];
      bit   dr = 0;
      int   seen = 0;
      if (host_start) begin
         repeat (start_low) begin step(1'b1); dr |= s_oe; end
         chk(!dr, "R3", {tag, " no drive in host start"}, int'(dr), 0);
      end else begin
         for (int i = 1; i <= 4 && seen == 0; i++) begin
            step(1'b0);
            if (s_oe && !s_o) seen = i;
         end
         chk(seen == 2, "R2", {tag, " start pulse clock"}, seen, 2);
         repeat (start_low - 1) begin step(1'b1); dr |= s_oe; end
         chk(!dr, "R2", {tag, " released after one low clock"}, int'(dr), 0);
      end
      for (int j = 0; j < SPAN; j++) begin
         step(1'b0);
         oe_l[j] = s_oe;
         o_l[j] = s_o;
         if (j == chg_j) req[chg_bit] = chg_val;
      end
      chk(!oe_l[0] && !oe_l[1], "R4", {tag, " lead clocks released"}, int'(oe_l[0] | oe_l[1]), 0);
      for (int k = 0; k < NF; k++) begin
         logic e;
         e = own[k] && !expv[k];
         chk(oe_l[3*k+2] == e && (!e || !o_l[3*k+2]), "R5", $sformatf("%s sample slot %0d", tag, k),
             int'(oe_l[3*k+2]), int'(e));
         chk(oe_l[3*k+3] == e && (!e || o_l[3*k+3]), "R6", $sformatf("%s recovery slot %0d", tag, k),
             int'(oe_l[3*k+3]), int'(e));
         chk(!oe_l[3*k+4], "R6", $sformatf("%s turn-around slot %0d", tag, k), int'(oe_l[3*k+4]), 0);
      end
      dr = 0;
      repeat (stop_low) begin step(1'b1); dr |= s_oe; end
      step(1'b0);
      dr |= s_oe;
      chk(!dr, "R11", {tag, " stop pulse released"}, int'(dr), 0);
   endtask

   initial begin
      logic [NF-1:0] ev;
      bit dr = 0;
      // R1: reset state
      repeat (3) begin step(1'b0); dr |= s_oe; end
      rst_n = 1'b1;
      repeat (5) begin step(1'b0); dr |= s_oe; end
      chk(!dr, "R1", "released in and after reset", int'(dr), 0);
      // R1/R3: continuous after reset, so an owned change starts nothing
      req[2] = 1'b0;
      quiet_watch(10, "R3 continuous mode");
      req[2] = 1'b1;
      step(1'b0);

      // Vector table: host-started cycles in continuous mode
      for (int v = 0; v < NVEC; v++) begin
         own = VEC[v].own;
         req = VEC[v].req;
         repeat (3) step(1'b0);
         do_cycle(1'b1, int'(VEC[v].start_low), int'(VEC[v].stop_low), VEC[v].req,
                  -1, 0, 1'b0, $sformatf("R4 vector %0d", v));
      end

      // Align everything, then a 2-clock stop selects quiet mode (R9)
      own = '1;
      req = '1;
      repeat (3) step(1'b0);
      do_cycle(1'b1, 4, 2, req, -1, 0, 1'b0, "R9 to quiet");
      quiet_watch(6, "R9 nothing pending");

      // R2/R10: agent starts a cycle on an owned change in quiet mode
      req[3] = 1'b0;
      do_cycle(1'b0, 4, 2, req, -1, 0, 1'b0, "R10 agent start");
      quiet_watch(10, "R8 delivered, no restart");

      // R7/R8: change captured at the edge opening slot 4's sample clock
      ev = req;
      ev[4] = 1'b0;
      do_cycle(1'b1, 5, 2, ev, 13, 4, 1'b0, "R7 early change");
      quiet_watch(10, "R8 early change no restart");

      // R7/R8: change in slot 8's own sample clock misses the slot
      ev = req;
      do_cycle(1'b1, 4, 2, ev, 26, 8, 1'b0, "R7 late change");
      do_cycle(1'b0, 4, 3, req, -1, 0, 1'b0, "R8 restart for late change");

      // R9: 3-clock stop restores continuous mode, so no start pulse
      req[3] = 1'b1;
      quiet_watch(10, "R9 continuous again");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule